// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the word address for a four-beat burst into a synchronous SRAM. Either of two start strobes captures a full external address. The upper bits are held for the whole burst. The bottom two bits then step through four beats each time the advance input is high, and they wrap to the captured value after the fourth beat. The order of the beats is chosen by an active-low order input: low gives a linear sequence that wraps around within the group of four, and high gives an interleaved sequence that is the captured low bits XOR'd with the beat number.

The block holds no storage or data path of its own. It registers the captured address and a two-bit beat counter, and derives the output address from them in combinational logic. A strobe can arrive on every clock, so a controller that never bursts loses no cycles. The order input has no internal pull in RTL. Where the interleaved default is wanted, the integrator ties it high.

Top module: `burst_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with no strobe, `addr_out` is all zeros and `beat` is 0.
- R2: When `start_a` or `start_b` is high at a rising edge, after that edge `addr_out` equals the `addr_in` value sampled at the edge and `beat` is 0.
- R3: When no strobe is high and `advance` is high at an edge, `beat` becomes (`beat` + 1) mod 4, and `addr_out[ADDR_W-1:2]` does not change.
- R4: With `order_n` = 0 (linear order), `addr_out[1:0]` equals (s + `beat`) mod 4, where s is the low two bits that were captured.
- R5: With `order_n` = 1 (interleaved order), `addr_out[1:0]` equals s XOR `beat`.
- R6: The fourth advance after a capture returns `addr_out` to the captured address and `beat` to 0.
- R7: When no strobe is high and `advance` is low at an edge, `beat` and the upper bits of `addr_out` keep their values, and the low bits keep their value when `order_n` is unchanged.
- R8: A strobe at the same edge as `advance` wins: the new address is loaded and `beat` is 0.
- R9: Strobes on consecutive edges each load their own address, with no idle cycle between them.
- R10: `order_n` acts on `addr_out` in the same cycle it changes, with no reload and no edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_a | input | 1 | First address strobe, active high |
| start_b | input | 1 | Second address strobe, active high |
| advance | input | 1 | Step the burst one beat, active high |
| order_n | input | 1 | Beat order: 0 linear, 1 interleaved (tie high by default) |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Beat index since the last load |

## Verification
A capture and a step can fall in the same cycle: a strobe arrives while `advance` is high. The bench raises one or both strobes during a burst with `advance` held high. It expects the newly presented address and beat 0, never the next beat of the old burst. The order input can also change mid-burst with no edge in between. The bench flips it while the beat is held and checks that the low address bits take the other order for the same beat at once.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_a,
  input  logic              start_b,
  input  logic              advance,
  input  logic              order_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  logic            load;
  logic [1:0]      lo;

  assign load = start_a | start_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      hi_q   <= addr_in[ADDR_W-1:2];
      base_q <= addr_in[1:0];
      cnt_q  <= '0;
    end else if (advance) begin
      cnt_q  <= cnt_q + 2'd1;
    end
  end

  assign lo       = order_n ? (base_q ^ cnt_q) : (base_q + cnt_q);
  assign addr_out = {hi_q, lo};
  assign beat     = cnt_q;

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_a,
  input logic              start_b,
  input logic              advance,
  input logic              order_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_a || start_b) |=> (addr_out == $past(addr_in) && beat == 2'd0));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && advance) |=>
      (beat == $past(beat) + 2'd1 && addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  assert_linear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && advance && !order_n) |=>
      (order_n || addr_out[1:0] == $past(addr_out[1:0]) + 2'd1));

  assert_interleave_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && advance && order_n) |=>
      (!order_n || (addr_out[1:0] ^ $past(addr_out[1:0])) == (beat ^ $past(beat))));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_a && !start_b && !advance) |=>
      ($stable(beat) && addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])));

  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_a || start_b) && advance) |=> (beat == 2'd0));

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/burst_seq_tb_top.sv
module burst_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 18;
  localparam int NVEC = 18;
  localparam int VW = 4 + AW + AW + 2;

  // {start_a, start_b, advance, order_n, addr_in, expected addr_out, expected beat}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {4'b1001, 18'h12345, 18'h12345, 2'd0},  // R2 load via start_a
    {4'b0011, 18'h00000, 18'h12344, 2'd1},  // R5 interleaved
    {4'b0011, 18'h00000, 18'h12347, 2'd2},  // R5
    {4'b0011, 18'h00000, 18'h12346, 2'd3},  // R5
    {4'b0011, 18'h00000, 18'h12345, 2'd0},  // R6 wrap
    {4'b0001, 18'h3FFFF, 18'h12345, 2'd0},  // R7 hold
    {4'b0100, 18'h2ABCE, 18'h2ABCE, 2'd0},  // R2 load via start_b
    {4'b0010, 18'h00000, 18'h2ABCF, 2'd1},  // R4 linear
    {4'b0010, 18'h00000, 18'h2ABCC, 2'd2},  // R4
    {4'b0010, 18'h00000, 18'h2ABCD, 2'd3},  // R4
    {4'b0000, 18'h11111, 18'h2ABCD, 2'd3},  // R7 hold
    {4'b0010, 18'h00000, 18'h2ABCE, 2'd0},  // R6 wrap
    {4'b1011, 18'h00003, 18'h00003, 2'd0},  // R8 load beats advance
    {4'b1001, 18'h3FFFC, 18'h3FFFC, 2'd0},  // R9 back-to-back
    {4'b0101, 18'h15557, 18'h15557, 2'd0},  // R9
    {4'b0011, 18'h00000, 18'h15556, 2'd1},  // R5
    {4'b0000, 18'h00000, 18'h15554, 2'd1},  // R10 order switched, no edge effect
    {4'b1110, 18'h0ABC9, 18'h0ABC9, 2'd0}   // R8 both strobes plus advance
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_a = 1'b0;
  logic          start_b = 1'b0;
  logic          advance = 1'b0;
  logic          order_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_a(start_a), .start_b(start_b),
    .advance(advance), .order_n(order_n), .addr_in(addr_in),
    .addr_out(addr_out), .beat(beat)
  );

  task automatic check(input string req, input logic [AW-1:0] ea, input logic [1:0] eb);
    checks++;
    if (addr_out !== ea || beat !== eb) begin
      errors++;
      $display("FAIL %s: addr_out=%h beat=%0d expected addr_out=%h beat=%0d",
               req, addr_out, beat, ea, eb);
    end
  endtask

  task automatic step(input logic sa, input logic sb, input logic adv,
                      input logic on, input logic [AW-1:0] a);
    start_a = sa; start_b = sb; advance = adv; order_n = on; addr_in = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: run still active, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", '0, 2'd0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF);
    check("R1 after release", '0, 2'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      step(v[VW-1], v[VW-2], v[VW-3], v[VW-4], v[2*AW+1:AW+2]);
      check($sformatf("vector %0d (R2-R10)", i), v[AW+1:2], v[1:0]);
    end

    // exhaustive start values in both orders: R4 R5 R6
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = {16'hA5C3, 2'(s)};
        step(1'b1, 1'b0, 1'b0, 1'(m), base);
        check("R2 sweep load", base, 2'd0);
        for (int n = 1; n <= 4; n++) begin
          logic [1:0] lo;
          lo = (m == 1) ? (2'(s) ^ 2'(n)) : 2'(s + n);
          step(1'b0, 1'b0, 1'b1, 1'(m), '0);
          check(m == 1 ? "R5 sweep interleaved / R6" : "R4 sweep linear / R6",
                {16'hA5C3, lo}, 2'(n));
        end
      end
    end

    // R10: flip order with beat held at 2, start low bits 01
    step(1'b0, 1'b1, 1'b0, 1'b0, 18'h00001);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R10 linear beat 2", 18'h00003, 2'd2);
    order_n = 1'b1;
    #1;
    check("R10 interleaved same beat", 18'h00003, 2'd2);
    order_n = 1'b0;
    #1;
    step(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R10 interleaved beat 3", 18'h00002, 2'd3);

    // R1 mid-run reset
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", '0, 2'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1, '0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b1, '0);
    check("R3 step after reset", 18'h00001, 2'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule